// File: doc/BRIEF.md
# Keyed SDRAM Command Gateway

This block is a small register-mapped port through which software sends one low-level command at a time to an external SDRAM controller's command stage. Software first programs a target address and, for commands that carry a payload, a transmit word. It then writes the command register. The write launches a command only when its upper half-word holds the unlock key and its low bits hold a supported operation code.

The launched command is held on a valid/acknowledge handshake toward the downstream side until that side acknowledges it, reports an error, or stays silent past a programmable number of cycles. Two sticky status bits report the outcome and are cleared by writing ones. Read commands leave the returned word in a receive register. Software polls the status bits, or uses the two matching interrupt lines.

Register word indices on `reg_idx`: 0 address, 1 transmit data, 2 command (reads as zero), 3 receive data (read only), 4 status, 5 timeout limit. All other indices read as zero and ignore writes.

Top module: `gwk_top`

## Requirements
- R1: After reset, `cmd_valid` is low, both status bits are clear, the address, transmit and receive registers read zero, and the timeout register reads the `TMO_RESET` parameter (default 64).
- R2: A command-register write whose bits [31:16] differ from 0xA55A launches nothing and sets the error bit (status bit 1).
- R3: A command-register write with key 0xA55A and a supported code, made while idle, raises `cmd_valid` on the next cycle with `cmd_code` equal to bits [3:0] and `cmd_addr` equal to the address register.
- R4: The supported codes are 0x8 read, 0x9 write, 0xA mode-register set, 0xB activate, 0xC auto refresh, 0xD self refresh, 0xE precharge and 0xF precharge all, with bits [15:4] zero. Any other low half-word, including the bus-master codes 0x0 and 0x1, sets the error bit and launches nothing.
- R5: For codes 0x9 and 0xA, `cmd_wdata` carries the transmit register as it was at launch. For every other code it is zero.
- R6: `cmd_valid` stays high with `cmd_code`, `cmd_addr` and `cmd_wdata` unchanged until a response or a timeout, and is low on the cycle after either.
- R7: `resp_ack` without `resp_err` sets the done bit (status bit 0). For a read command, `resp_rdata` is stored in the receive register. Any other command leaves the receive register unchanged.
- R8: `resp_err` while a command is pending sets the error bit and does not set the done bit.
- R9: If no response arrives, `cmd_valid` is high for exactly max(T,1) cycles, where T is the timeout register, and then drops with the error bit set.
- R10: A command-register write while a command is pending sets the error bit and leaves the pending command unchanged.
- R11: Writing the status register clears each bit written with a one and keeps each bit written with a zero. A new event in the same cycle takes priority over the clear.
- R12: The address, transmit and timeout registers read back the last value written. The status register reads done in bit 0 and error in bit 1. `irq_done` and `irq_err` follow those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_idx`) |
| cmd_valid | output | 1 | Command pending toward the SDRAM side |
| cmd_code | output | 4 | Operation code of the pending command |
| cmd_addr | output | 32 | Target address of the pending command |
| cmd_wdata | output | 32 | Payload of the pending command |
| resp_ack | input | 1 | Downstream acknowledge |
| resp_err | input | 1 | Downstream error (wins over ack) |
| resp_rdata | input | 32 | Read data returned with the acknowledge |
| irq_done | output | 1 | Sticky done status |
| irq_err | output | 1 | Sticky error status |

## Verification
The assertions assume that the downstream side raises `resp_ack` or `resp_err` only while `cmd_valid` is high, and that at most one register write is presented per cycle. The directed stimulus keeps to these assumptions. The stub responder in the bench drives a response for a single cycle, only on a cycle where it has just seen `cmd_valid` high, and otherwise holds the response lines low. Register writes are issued one per task call, and each call ends with the strobe dropped.

// File: rtl/gwk_pkg.sv
package gwk_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 3;
    localparam int KEY_W   = 16;
    localparam int KEY_LSB = DATA_W - KEY_W;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA55A;

    typedef enum logic [IDX_W-1:0] {
        RI_ADDR = 3'd0,
        RI_TXD  = 3'd1,
        RI_CMD  = 3'd2,
        RI_RXD  = 3'd3,
        RI_STAT = 3'd4,
        RI_TMO  = 3'd5
    } reg_idx_e;

    typedef enum logic [3:0] {
        OP_READ    = 4'h8,
        OP_WRITE   = 4'h9,
        OP_MODESET = 4'hA,
        OP_ACT     = 4'hB,
        OP_AREF    = 4'hC,
        OP_SREF    = 4'hD,
        OP_PRE     = 4'hE,
        OP_PREALL  = 4'hF
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } sdcmd_t;

    function automatic logic key_matches(input logic [DATA_W-1:0] w);
        return w[DATA_W-1:KEY_LSB] == UNLOCK_KEY;
    endfunction

    // supported: bit 3 set, all other low-half bits above the code clear
    function automatic logic op_supported(input logic [DATA_W-1:0] w);
        return (w[KEY_LSB-1:4] == '0) && w[3];
    endfunction

    function automatic logic op_has_payload(input op_e op);
        return (op == OP_WRITE) || (op == OP_MODESET);
    endfunction

endpackage

// File: rtl/gwk_keycheck.sv
module gwk_keycheck
    import gwk_pkg::*;
(
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_word,
    input  logic              busy,
    output logic              launch,
    output logic              reject,
    output op_e               op
);
    logic word_ok;

    always_comb begin
        word_ok = key_matches(cmd_word) && op_supported(cmd_word);
        launch  = cmd_wr && word_ok && !busy;
        reject  = cmd_wr && (!word_ok || busy);
        op      = op_e'(cmd_word[3:0]);
    end

endmodule

// File: rtl/gwk_issuer.sv
module gwk_issuer
    import gwk_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  op_e               launch_op,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] txd_q,
    input  logic [TMO_W-1:0]  tmo_q,
    input  logic              resp_ack,
    input  logic              resp_err,
    input  logic [DATA_W-1:0] resp_rdata,
    output logic              busy,
    output sdcmd_t            cur,
    output logic              evt_done,
    output logic              evt_fail,
    output logic              rx_we,
    output logic [DATA_W-1:0] rx_data
);
    localparam int CNT_W = TMO_W + 1;

    logic [TMO_W-1:0] wait_cnt;
    logic             tmo_hit;
    logic             got_resp;

    always_comb begin
        got_resp = busy && (resp_ack || resp_err);
        tmo_hit  = busy && !resp_ack && !resp_err &&
                   ((CNT_W'(wait_cnt) + CNT_W'(1)) >= CNT_W'(tmo_q));
        evt_done = busy && resp_ack && !resp_err;
        evt_fail = (busy && resp_err) || tmo_hit;
        rx_we    = evt_done && (cur.op == OP_READ);
        rx_data  = resp_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            wait_cnt <= '0;
            cur      <= '{op: OP_READ, addr: '0, data: '0};
        end else if (launch) begin
            busy     <= 1'b1;
            wait_cnt <= '0;
            cur.op   <= launch_op;
            cur.addr <= addr_q;
            cur.data <= op_has_payload(launch_op) ? txd_q : '0;
        end else if (busy) begin
            if (got_resp || tmo_hit) begin
                busy <= 1'b0;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

    AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !launch);                                                  // R10
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(launch)) |-> $stable(cur));          // R6
    AST_RESP_ENDS_CMD: assert property (@(posedge clk) disable iff (rst)
        (busy && (resp_ack || resp_err)) |=> !busy);                        // R6
    AST_PAYLOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (busy && !op_has_payload(cur.op)) |-> (cur.data == '0));            // R5

endmodule

// File: rtl/gwk_regs.sv
module gwk_regs
    import gwk_pkg::*;
#(
    parameter int              TMO_W     = 16,
    parameter logic [TMO_W-1:0] TMO_RESET = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              evt_done,
    input  logic              evt_err,
    input  logic              rx_we,
    input  logic [DATA_W-1:0] rx_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] txd_q,
    output logic [TMO_W-1:0]  tmo_q,
    output logic              done_q,
    output logic              err_q,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [DATA_W-1:0] rxd_q;
    logic              stat_wr;
    logic              done_d;
    logic              err_d;

    always_comb begin
        stat_wr = reg_we && (reg_idx == RI_STAT);
        done_d  = done_q;
        err_d   = err_q;
        if (stat_wr && reg_wdata[0]) done_d = 1'b0;
        if (stat_wr && reg_wdata[1]) err_d  = 1'b0;
        if (evt_done) done_d = 1'b1;
        if (evt_err)  err_d  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            txd_q  <= '0;
            tmo_q  <= TMO_RESET;
            rxd_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= done_d;
            err_q  <= err_d;
            if (rx_we) rxd_q <= rx_data;
            if (reg_we) begin
                case (reg_idx)
                    RI_ADDR: addr_q <= reg_wdata;
                    RI_TXD:  txd_q  <= reg_wdata;
                    RI_TMO:  tmo_q  <= reg_wdata[TMO_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_idx)
            RI_ADDR: reg_rdata = addr_q;
            RI_TXD:  reg_rdata = txd_q;
            RI_RXD:  reg_rdata = rxd_q;
            RI_STAT: reg_rdata = {{(DATA_W-2){1'b0}}, err_q, done_q};
            RI_TMO:  reg_rdata = DATA_W'(tmo_q);
            default: reg_rdata = '0;
        endcase
    end

    AST_W1C_DONE: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && reg_wdata[0] && !evt_done) |=> !done_q);                // R11
    AST_W1C_KEEP_ERR: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(stat_wr && reg_wdata[1])) |=> err_q);                   // R11
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        evt_err |=> err_q);                                                 // R11

endmodule

// File: rtl/gwk_top.sv
module gwk_top
    import gwk_pkg::*;
#(
    parameter int              TMO_W     = 16,
    parameter logic [TMO_W-1:0] TMO_RESET = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        cmd_valid,
    output logic [3:0]  cmd_code,
    output logic [31:0] cmd_addr,
    output logic [31:0] cmd_wdata,
    input  logic        resp_ack,
    input  logic        resp_err,
    input  logic [31:0] resp_rdata,
    output logic        irq_done,
    output logic        irq_err
);
    logic              launch;
    logic              reject;
    op_e               launch_op;
    logic              busy;
    sdcmd_t            cur;
    logic              evt_done;
    logic              evt_fail;
    logic              rx_we;
    logic [DATA_W-1:0] rx_data;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] txd_q;
    logic [TMO_W-1:0]  tmo_q;
    logic              done_q;
    logic              err_q;
    logic              cmd_wr;

    assign cmd_wr = reg_we && (reg_idx == RI_CMD);

    gwk_keycheck u_key (
        .cmd_wr   (cmd_wr),
        .cmd_word (reg_wdata),
        .busy     (busy),
        .launch   (launch),
        .reject   (reject),
        .op       (launch_op)
    );

    gwk_issuer #(.TMO_W(TMO_W)) u_iss (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_op  (launch_op),
        .addr_q     (addr_q),
        .txd_q      (txd_q),
        .tmo_q      (tmo_q),
        .resp_ack   (resp_ack),
        .resp_err   (resp_err),
        .resp_rdata (resp_rdata),
        .busy       (busy),
        .cur        (cur),
        .evt_done   (evt_done),
        .evt_fail   (evt_fail),
        .rx_we      (rx_we),
        .rx_data    (rx_data)
    );

    gwk_regs #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .evt_done  (evt_done),
        .evt_err   (evt_fail || reject),
        .rx_we     (rx_we),
        .rx_data   (rx_data),
        .addr_q    (addr_q),
        .txd_q     (txd_q),
        .tmo_q     (tmo_q),
        .done_q    (done_q),
        .err_q     (err_q),
        .reg_rdata (reg_rdata)
    );

    assign cmd_valid = busy;
    assign cmd_code  = cur.op;
    assign cmd_addr  = cur.addr;
    assign cmd_wdata = cur.data;
    assign irq_done  = done_q;
    assign irq_err   = err_q;

    AST_BAD_KEY_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && reg_wdata[31:16] != 16'hA55A && !cmd_valid)
            |=> (!cmd_valid && irq_err));                                   // R2
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_code[3]);                                         // R4
    AST_ACK_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && resp_ack && !resp_err) |=> irq_done);                 // R7
    AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && resp_err && !irq_done) |=> (irq_err && !irq_done));   // R8
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_wr && !resp_ack && !resp_err)
            |=> (cmd_valid && $stable(cmd_code) && irq_err));               // R10

endmodule

// File: tb/tb_gwk_top.sv
module tb_gwk_top;

    localparam logic [31:0] KEY = 32'hA55A_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid;
    logic [3:0]  cmd_code;
    logic [31:0] cmd_addr;
    logic [31:0] cmd_wdata;
    logic        resp_ack = 1'b0;
    logic        resp_err = 1'b0;
    logic [31:0] resp_rdata = '0;
    logic        irq_done;
    logic        irq_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    gwk_top dut (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_idx    (reg_idx),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .resp_ack   (resp_ack),
        .resp_err   (resp_err),
        .resp_rdata (resp_rdata),
        .irq_done   (irq_done),
        .irq_err    (irq_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic respond(input logic ack, input logic err, input logic [31:0] data);
        resp_ack = ack; resp_err = err; resp_rdata = data;
        @(negedge clk);
        resp_ack = 1'b0; resp_err = 1'b0; resp_rdata = '0;
    endtask

    task automatic clear_status();
        wr(3'd4, 32'h3);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1", "cmd_valid", {31'b0, cmd_valid}, 32'd0);
        rd(3'd4, v); chk("R1", "status", v, 32'd0);
        rd(3'd0, v); chk("R1", "addr", v, 32'd0);
        rd(3'd1, v); chk("R1", "txd", v, 32'd0);
        rd(3'd3, v); chk("R1", "rxd", v, 32'd0);
        rd(3'd5, v); chk("R1", "timeout", v, 32'd64);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(3'd0, 32'h8000_1000);
        wr(3'd1, 32'hDEAD_BEEF);
        wr(3'd5, 32'd20);
        rd(3'd0, v); chk("R12", "addr readback", v, 32'h8000_1000);
        rd(3'd1, v); chk("R12", "txd readback", v, 32'hDEAD_BEEF);
        rd(3'd5, v); chk("R12", "timeout readback", v, 32'd20);
        rd(3'd2, v); chk("R12", "cmd reads zero", v, 32'd0);
    endtask

    task automatic t_write_cmd();
        logic [31:0] v;
        wr(3'd2, KEY | 32'h9);
        chk("R3", "valid after write cmd", {31'b0, cmd_valid}, 32'd1);
        chk("R3", "code", {28'b0, cmd_code}, 32'h9);
        chk("R3", "addr", cmd_addr, 32'h8000_1000);
        chk("R5", "write payload", cmd_wdata, 32'hDEAD_BEEF);
        wr(3'd1, 32'h1111_2222);
        chk("R6", "payload held", cmd_wdata, 32'hDEAD_BEEF);
        respond(1'b1, 1'b0, 32'h0);
        chk("R6", "valid drops", {31'b0, cmd_valid}, 32'd0);
        rd(3'd4, v); chk("R7", "done bit", v, 32'h1);
        chk("R12", "irq_done", {31'b0, irq_done}, 32'd1);
        clear_status();
        rd(3'd4, v); chk("R11", "cleared", v, 32'h0);
    endtask

    task automatic t_read_cmd();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0040);
        wr(3'd2, KEY | 32'h8);
        chk("R3", "read code", {28'b0, cmd_code}, 32'h8);
        chk("R3", "read addr", cmd_addr, 32'h40);
        chk("R5", "read zero payload", cmd_wdata, 32'h0);
        @(negedge clk);
        respond(1'b1, 1'b0, 32'h1234_5678);
        rd(3'd3, v); chk("R7", "rx captured", v, 32'h1234_5678);
        clear_status();
        wr(3'd2, KEY | 32'hB);
        respond(1'b1, 1'b0, 32'hFFFF_FFFF);
        rd(3'd3, v); chk("R7", "rx kept after activate", v, 32'h1234_5678);
        rd(3'd4, v); chk("R7", "activate done", v, 32'h1);
        clear_status();
    endtask

    task automatic t_modeset();
        wr(3'd1, 32'h0000_0032);
        wr(3'd2, KEY | 32'hA);
        chk("R5", "modeset payload", cmd_wdata, 32'h32);
        respond(1'b1, 1'b0, 32'h0);
        clear_status();
    endtask

    task automatic t_bad_key();
        logic [31:0] v;
        wr(3'd2, 32'hA55B_0008);
        chk("R2", "no launch on bad key", {31'b0, cmd_valid}, 32'd0);
        rd(3'd4, v); chk("R2", "error bit", v, 32'h2);
        wr(3'd4, 32'h1);
        rd(3'd4, v); chk("R11", "zero keeps error", v, 32'h2);
        wr(3'd4, 32'h2);
        rd(3'd4, v); chk("R11", "one clears error", v, 32'h0);
    endtask

    task automatic t_unsupported();
        logic [31:0] v;
        logic [31:0] words [3] = '{KEY | 32'h1, KEY | 32'h0, KEY | 32'h18};
        foreach (words[i]) begin
            wr(3'd2, words[i]);
            chk("R4", "no launch unsupported", {31'b0, cmd_valid}, 32'd0);
            rd(3'd4, v); chk("R4", "error unsupported", v, 32'h2);
            clear_status();
        end
    endtask

    task automatic t_resp_err();
        logic [31:0] v;
        wr(3'd2, KEY | 32'hE);
        respond(1'b1, 1'b1, 32'h0);
        chk("R8", "valid drops on err", {31'b0, cmd_valid}, 32'd0);
        rd(3'd4, v); chk("R8", "err not done", v, 32'h2);
        clear_status();
    endtask

    task automatic t_timeout(input int t, input int exp_cycles);
        logic [31:0] v;
        int n = 0;
        wr(3'd5, t);
        wr(3'd2, KEY | 32'hC);
        while (cmd_valid && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R9", "valid cycles", n, exp_cycles);
        rd(3'd4, v); chk("R9", "timeout error", v, 32'h2);
        clear_status();
    endtask

    task automatic t_busy();
        logic [31:0] v;
        wr(3'd5, 32'd50);
        wr(3'd2, KEY | 32'hC);
        wr(3'd2, KEY | 32'hF);
        chk("R10", "still pending", {31'b0, cmd_valid}, 32'd1);
        chk("R10", "code unchanged", {28'b0, cmd_code}, 32'hC);
        rd(3'd4, v); chk("R10", "refusal error", v, 32'h2);
        respond(1'b1, 1'b0, 32'h0);
        rd(3'd4, v); chk("R10", "first completes", v, 32'h3);
        clear_status();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_write_cmd();
        t_read_cmd();
        t_modeset();
        t_bad_key();
        t_unsupported();
        t_resp_err();
        t_timeout(5, 5);
        t_timeout(0, 1);
        t_busy();
        finish_run();
    end

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule